// File: doc/BRIEF.md
# Dual-Bank Prioritised Interrupt Controller

The block takes up to 32 interrupt inputs and presents them to a processor on two request lines, a normal line and a fast line. Each source first passes a shared polarity stage and an optional capture latch, then goes through a per-source priority. Each of the two banks applies its own enable mask and its own priority threshold to that shared pending vector. A bank's request line is high whenever at least one of its sources is pending, enabled and within the threshold.

Software works through a single-cycle register bus. The bus has a select, a write flag, a 12-bit byte address and 32-bit data, and read data comes back in the same cycle. A handler polls the bank's masked status until it reads zero. Inside that loop it reads the current-source register to get the winning index, then reads the bank's acknowledge register. That read is the acknowledge: it clears the capture latch of the source named as current. Enable bits are set and cleared through two separate write-one registers, so that no read-modify-write is needed.

Top module: `dual_bank_intc`

## Requirements
- R1: After reset every enable bit is 0, every polarity bit is 1, every capture-select bit is 0, every priority is 0, both thresholds are 0xF, and both request lines are low.
- R2: Within a bank (base 0x000 normal, 0x100 fast), writing offset 0x08 sets the enable bits where the data is 1, and writing offset 0x0C clears the enable bits where the data is 1. All other bits keep their value, and a read of 0x08 returns the mask.
- R3: Polarity register 0x200: a bit of 1 passes source n as-is and a bit of 0 inverts it. Raw status (bank offset 0x04) shows the pending vector, which is the same for both banks.
- R4: Capture register 0x204: with bit n at 1, an active source n sets a latch that keeps it pending after the input drops. With bit n at 0, the source is pending only while it is active.
- R5: Masked status (bank offset 0x00) is pending AND enable AND (priority <= threshold). The threshold is 4 bits at bank offset 0x2C. The bank's request line is high exactly when masked status is nonzero.
- R6: Current source (bank offset 0x20) returns the masked source with the numerically lowest priority. On a tie the lowest index wins. The register reads 0 when nothing is masked.
- R7: A read of bank offset 0x28 returns 0 and clears the capture latch of that bank's current source only. A source that is still active latches again. An acknowledge with nothing masked changes nothing.
- R8: The enable masks and thresholds of the two banks are independent. Writes to one bank never change the other bank's mask, threshold, status or line.
- R9: The priority of source n sits at 0x300 + 4*n. Only the low 4 bits are stored, and a read returns them zero-extended.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| src_i | input | NSRC | Interrupt inputs, synchronous to clk |
| bus_sel | input | 1 | Register access this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Byte address |
| bus_wdata | input | DW | Write data |
| bus_rdata | output | DW | Read data, same cycle |
| irq_o | output | 1 | Normal-bank request line |
| fiq_o | output | 1 | Fast-bank request line |

## Verification
The bench sweeps all sixteen thresholds against pseudo-random source patterns. It uses a priority assignment that repeats every sixteen sources, so equal-priority ties occur constantly. A design that used `<` instead of `<=` against the threshold, or that broke ties toward the higher index, would report the wrong current source or drop priority-0xF sources. Capture is tested with short pulses: a latch that fails to hold loses the request once the input falls. An acknowledge that clears every latch, or a latch cleared in the wrong bank, shows up as a raw-status bit vanishing too early. Inverted polarity and one-bank-only enable writes are checked to catch a shared mask or a swapped polarity sense.

// File: rtl/intc_pkg.sv
package intc_pkg;
  // Offsets inside a bank page (byte addresses)
  localparam logic [7:0] OFF_MSTAT = 8'h00;
  localparam logic [7:0] OFF_RAW   = 8'h04;
  localparam logic [7:0] OFF_EN    = 8'h08;
  localparam logic [7:0] OFF_DIS   = 8'h0C;
  localparam logic [7:0] OFF_CUR   = 8'h20;
  localparam logic [7:0] OFF_ACK   = 8'h28;
  localparam logic [7:0] OFF_THR   = 8'h2C;
  // Offsets inside the shared page
  localparam logic [7:0] OFF_POL   = 8'h00;
  localparam logic [7:0] OFF_CAPT  = 8'h04;

  // Address pages (bus_addr[11:8])
  localparam logic [3:0] PAGE_SHARED = 4'h2;
  localparam logic [3:0] PAGE_PRIO   = 4'h3;

  typedef enum logic {
    BANK_IRQ = 1'b0,
    BANK_FIQ = 1'b1
  } bank_e;

  localparam int NBANK = 2;

  typedef struct packed {
    logic set_en;
    logic clr_en;
    logic wr_thr;
    logic ack;
  } bank_cmd_t;
endpackage

// File: rtl/intc_cfg_regs.sv
module intc_cfg_regs #(
  parameter int NSRC   = 32,
  parameter int PRIO_W = 4,
  localparam int IDX_W = (NSRC > 1) ? $clog2(NSRC) : 1
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              wr_pol,
  input  logic                              wr_capt,
  input  logic                              wr_prio,
  input  logic [IDX_W-1:0]                  prio_idx,
  input  logic [NSRC-1:0]                   wdata,
  output logic [NSRC-1:0]                   pol_q,
  output logic [NSRC-1:0]                   capt_q,
  output logic [NSRC-1:0][PRIO_W-1:0]       prio_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pol_q  <= '1;
      capt_q <= '0;
    end else begin
      if (wr_pol)  pol_q  <= wdata;
      if (wr_capt) capt_q <= wdata;
    end
  end

  for (genvar n = 0; n < NSRC; n++) begin : g_prio
    logic hit;
    assign hit = wr_prio && (prio_idx == IDX_W'(n));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   prio_q[n] <= '0;
      else if (hit) prio_q[n] <= wdata[PRIO_W-1:0];
    end
  end
endmodule

// File: rtl/intc_src_cond.sv
module intc_src_cond #(
  parameter int NSRC = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] src_i,
  input  logic [NSRC-1:0] pol_q,
  input  logic [NSRC-1:0] capt_q,
  input  logic [NSRC-1:0] clr_vec,
  output logic [NSRC-1:0] active,
  output logic [NSRC-1:0] latch_q,
  output logic [NSRC-1:0] pend
);
  // Polarity: 1 passes the input, 0 inverts it
  function automatic logic [NSRC-1:0] apply_pol(input logic [NSRC-1:0] s,
                                                input logic [NSRC-1:0] p);
    return s ^ ~p;
  endfunction

  assign active = apply_pol(src_i, pol_q);

  // Capture latch: set by activity, cleared by acknowledge; set wins
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) latch_q <= '0;
    else        latch_q <= capt_q & ((latch_q & ~clr_vec) | active);
  end

  assign pend = active | (latch_q & capt_q);
endmodule

// File: rtl/intc_bank.sv
module intc_bank #(
  parameter int NSRC   = 32,
  parameter int PRIO_W = 4,
  localparam int IDX_W = (NSRC > 1) ? $clog2(NSRC) : 1
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [NSRC-1:0]             pend,
  input  logic [NSRC-1:0][PRIO_W-1:0] prio_q,
  input  intc_pkg::bank_cmd_t         cmd,
  input  logic [NSRC-1:0]             wdata,
  output logic [NSRC-1:0]             en_q,
  output logic [PRIO_W-1:0]           thr_q,
  output logic [NSRC-1:0]             masked,
  output logic                        any,
  output logic [IDX_W-1:0]            cur_idx,
  output logic [NSRC-1:0]             clr_vec
);
  // Lowest priority value wins; strict compare in ascending scan keeps
  // the lowest index on ties.
  function automatic logic [IDX_W-1:0] best_source(
      input logic [NSRC-1:0]             cand,
      input logic [NSRC-1:0][PRIO_W-1:0] pr);
    logic [IDX_W-1:0]  win;
    logic [PRIO_W-1:0] wp;
    logic              found;
    win   = '0;
    wp    = '1;
    found = 1'b0;
    for (int n = 0; n < NSRC; n++) begin
      if (cand[n] && (!found || (pr[n] < wp))) begin
        win   = IDX_W'(n);
        wp    = pr[n];
        found = 1'b1;
      end
    end
    return win;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q  <= '0;
      thr_q <= '1;
    end else begin
      if (cmd.set_en)      en_q <= en_q | wdata;
      else if (cmd.clr_en) en_q <= en_q & ~wdata;
      if (cmd.wr_thr)      thr_q <= wdata[PRIO_W-1:0];
    end
  end

  logic [NSRC-1:0] qual;
  for (genvar n = 0; n < NSRC; n++) begin : g_qual
    assign qual[n]    = (prio_q[n] <= thr_q);
    assign clr_vec[n] = cmd.ack && any && (cur_idx == IDX_W'(n));
  end

  assign masked  = pend & en_q & qual;
  assign any     = |masked;
  assign cur_idx = best_source(masked, prio_q);
endmodule

// File: rtl/dual_bank_intc.sv
module dual_bank_intc #(
  parameter int NSRC   = 32,
  parameter int PRIO_W = 4,
  parameter int DW     = 32,
  localparam int IDX_W = (NSRC > 1) ? $clog2(NSRC) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] src_i,
  input  logic            bus_sel,
  input  logic            bus_wr,
  input  logic [11:0]     bus_addr,
  input  logic [DW-1:0]   bus_wdata,
  output logic [DW-1:0]   bus_rdata,
  output logic            irq_o,
  output logic            fiq_o
);
  import intc_pkg::*;

  function automatic logic [DW-1:0] widen(input logic [NSRC-1:0] v);
    logic [DW-1:0] r;
    r = '0;
    r[NSRC-1:0] = v;
    return r;
  endfunction

  // Bus decode
  logic       wr_acc, rd_acc;
  logic [3:0] page;
  logic [7:0] off;
  logic       prio_addr_ok;
  logic [IDX_W-1:0] prio_idx;
  logic [NSRC-1:0]  wdata_src;

  assign wr_acc       = bus_sel && bus_wr;
  assign rd_acc       = bus_sel && !bus_wr;
  assign page         = bus_addr[11:8];
  assign off          = bus_addr[7:0];
  assign prio_addr_ok = (page == PAGE_PRIO) && (bus_addr[1:0] == 2'b00) &&
                        ({1'b0, bus_addr[7:2]} < 7'(NSRC));
  assign prio_idx     = bus_addr[2 +: IDX_W];
  assign wdata_src    = bus_wdata[NSRC-1:0];

  logic wr_pol, wr_capt, wr_prio;
  assign wr_pol  = wr_acc && (page == PAGE_SHARED) && (off == OFF_POL);
  assign wr_capt = wr_acc && (page == PAGE_SHARED) && (off == OFF_CAPT);
  assign wr_prio = wr_acc && prio_addr_ok;

  // Shared configuration
  logic [NSRC-1:0]             pol_q, capt_q;
  logic [NSRC-1:0][PRIO_W-1:0] prio_q;

  intc_cfg_regs #(.NSRC(NSRC), .PRIO_W(PRIO_W)) u_cfg (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_pol   (wr_pol),
    .wr_capt  (wr_capt),
    .wr_prio  (wr_prio),
    .prio_idx (prio_idx),
    .wdata    (wdata_src),
    .pol_q    (pol_q),
    .capt_q   (capt_q),
    .prio_q   (prio_q)
  );

  // Source conditioning
  logic [NSRC-1:0] active, latch_q, pend, clr_vec;

  intc_src_cond #(.NSRC(NSRC)) u_src (
    .clk     (clk),
    .rst_n   (rst_n),
    .src_i   (src_i),
    .pol_q   (pol_q),
    .capt_q  (capt_q),
    .clr_vec (clr_vec),
    .active  (active),
    .latch_q (latch_q),
    .pend    (pend)
  );

  // Banks
  logic [NBANK-1:0][NSRC-1:0]   en_b, masked_b, clr_b;
  logic [NBANK-1:0][PRIO_W-1:0] thr_b;
  logic [NBANK-1:0][IDX_W-1:0]  cur_b;
  logic [NBANK-1:0]             any_b;
  bank_cmd_t                    cmd_b [NBANK];

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    logic in_bank;
    assign in_bank          = (page == 4'(b));
    assign cmd_b[b].set_en  = wr_acc && in_bank && (off == OFF_EN);
    assign cmd_b[b].clr_en  = wr_acc && in_bank && (off == OFF_DIS);
    assign cmd_b[b].wr_thr  = wr_acc && in_bank && (off == OFF_THR);
    assign cmd_b[b].ack     = rd_acc && in_bank && (off == OFF_ACK);

    intc_bank #(.NSRC(NSRC), .PRIO_W(PRIO_W)) u_bank (
      .clk     (clk),
      .rst_n   (rst_n),
      .pend    (pend),
      .prio_q  (prio_q),
      .cmd     (cmd_b[b]),
      .wdata   (wdata_src),
      .en_q    (en_b[b]),
      .thr_q   (thr_b[b]),
      .masked  (masked_b[b]),
      .any     (any_b[b]),
      .cur_idx (cur_b[b]),
      .clr_vec (clr_b[b])
    );
  end

  assign clr_vec = clr_b[BANK_IRQ] | clr_b[BANK_FIQ];

  // Named events for the checker
  logic            set_irq, dis_irq;
  logic [NSRC-1:0] en_irq, en_fiq, masked_irq;
  logic [IDX_W-1:0] cur_irq;
  assign set_irq    = cmd_b[BANK_IRQ].set_en;
  assign dis_irq    = cmd_b[BANK_IRQ].clr_en;
  assign en_irq     = en_b[BANK_IRQ];
  assign en_fiq     = en_b[BANK_FIQ];
  assign masked_irq = masked_b[BANK_IRQ];
  assign cur_irq    = cur_b[BANK_IRQ];

  assign irq_o = any_b[BANK_IRQ];
  assign fiq_o = any_b[BANK_FIQ];

  // Read mux
  logic rd_bank;
  assign rd_bank = page[0];

  always_comb begin
    bus_rdata = '0;
    if (page == 4'h0 || page == 4'h1) begin
      case (off)
        OFF_MSTAT: bus_rdata = widen(masked_b[rd_bank]);
        OFF_RAW:   bus_rdata = widen(pend);
        OFF_EN:    bus_rdata = widen(en_b[rd_bank]);
        OFF_CUR:   bus_rdata = DW'(cur_b[rd_bank]);
        OFF_THR:   bus_rdata = DW'(thr_b[rd_bank]);
        default:   bus_rdata = '0;
      endcase
    end else if (page == PAGE_SHARED) begin
      if (off == OFF_POL)       bus_rdata = widen(pol_q);
      else if (off == OFF_CAPT) bus_rdata = widen(capt_q);
    end else if (prio_addr_ok) begin
      bus_rdata = DW'(prio_q[prio_idx]);
    end
  end
endmodule

// File: rtl/dual_bank_intc_chk.sv
module dual_bank_intc_chk #(
  parameter int NSRC  = 32,
  parameter int IDX_W = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic             irq_o,
  input logic             fiq_o,
  input logic [NSRC-1:0]  en_irq,
  input logic [NSRC-1:0]  en_fiq,
  input logic [NSRC-1:0]  pend,
  input logic [NSRC-1:0]  latch_q,
  input logic [NSRC-1:0]  capt_q,
  input logic [NSRC-1:0]  clr_vec,
  input logic             set_irq,
  input logic             dis_irq,
  input logic [NSRC-1:0]  wdata_src,
  input logic [NSRC-1:0]  masked_irq,
  input logic [IDX_W-1:0] cur_irq
);
  assert_enable_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
    set_irq |=> ((en_irq & $past(wdata_src)) == $past(wdata_src)));

  assert_disable_clr_R2: assert property (@(posedge clk) disable iff (!rst_n)
    dis_irq |=> ((en_irq & $past(wdata_src)) == '0));

  assert_enable_stable_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!set_irq && !dis_irq) |=> $stable(en_irq));

  assert_irq_needs_enable_R5: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> ((pend & en_irq) != '0));

  assert_fiq_needs_enable_R8: assert property (@(posedge clk) disable iff (!rst_n)
    fiq_o |-> ((pend & en_fiq) != '0));

  assert_capture_holds_R4: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (($past(latch_q & capt_q & ~clr_vec) & ~latch_q) == '0));

  assert_ack_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(clr_vec));

  assert_cur_qualifies_R6: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> masked_irq[cur_irq]);
endmodule

bind dual_bank_intc dual_bank_intc_chk #(.NSRC(NSRC), .IDX_W(IDX_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .irq_o      (irq_o),
  .fiq_o      (fiq_o),
  .en_irq     (en_irq),
  .en_fiq     (en_fiq),
  .pend       (pend),
  .latch_q    (latch_q),
  .capt_q     (capt_q),
  .clr_vec    (clr_vec),
  .set_irq    (set_irq),
  .dis_irq    (dis_irq),
  .wdata_src  (wdata_src),
  .masked_irq (masked_irq),
  .cur_irq    (cur_irq)
);

// File: tb/dual_bank_intc_tb.sv
module dual_bank_intc_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] src = '0;
  logic        sel = 1'b0;
  logic        wr = 1'b0;
  logic [11:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq_o, fiq_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dual_bank_intc u_dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .src_i     (src),
    .bus_sel   (sel),
    .bus_wr    (wr),
    .bus_addr  (addr),
    .bus_wdata (wdata),
    .bus_rdata (rdata),
    .irq_o     (irq_o),
    .fiq_o     (fiq_o)
  );

  // Reference state, built from the requirements
  logic [31:0] m_pol = '1;
  logic [31:0] m_capt = '0;
  logic [31:0] m_latch = '0;
  logic [3:0]  m_prio [32];
  logic [31:0] m_en [2];
  logic [3:0]  m_thr [2];

  function automatic logic [31:0] m_pend();
    return (src ^ ~m_pol) | (m_latch & m_capt);
  endfunction

  function automatic logic [31:0] m_masked(input int b);
    logic [31:0] p, r;
    p = m_pend();
    r = '0;
    for (int n = 0; n < 32; n++)
      r[n] = p[n] && m_en[b][n] && (m_prio[n] <= m_thr[b]);
    return r;
  endfunction

  function automatic int m_cur(input int b);
    logic [31:0] mk;
    mk = m_masked(b);
    for (int p = 0; p < 16; p++)
      for (int n = 0; n < 32; n++)
        if (mk[n] && m_prio[n] == p[3:0]) return n;
    return 0;
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
    end
  endtask

  // One clock with the model updated at the edge from pre-edge values
  task automatic step();
    logic [31:0] clr, act;
    int b;
    clr = '0;
    act = src ^ ~m_pol;
    if (sel && !wr && addr[11:9] == 3'b000 && addr[7:0] == 8'h28) begin
      b = int'(addr[8]);
      if (m_masked(b) != 0) clr = 32'h1 << m_cur(b);
    end
    @(posedge clk);
    m_latch = m_capt & ((m_latch & ~clr) | act);
    if (sel && wr) begin
      if (addr[11:9] == 3'b000) begin
        b = int'(addr[8]);
        case (addr[7:0])
          8'h08: m_en[b] = m_en[b] | wdata;
          8'h0C: m_en[b] = m_en[b] & ~wdata;
          8'h2C: m_thr[b] = wdata[3:0];
          default: ;
        endcase
      end else if (addr == 12'h200) m_pol = wdata;
      else if (addr == 12'h204) m_capt = wdata;
      else if (addr[11:8] == 4'h3 && addr[1:0] == 2'b00 && addr[7] == 1'b0)
        m_prio[addr[6:2]] = wdata[3:0];
    end
    @(negedge clk);
    sel = 1'b0;
    wr  = 1'b0;
  endtask

  task automatic bus_write(input logic [11:0] a, input logic [31:0] d);
    sel = 1'b1; wr = 1'b1; addr = a; wdata = d;
    step();
  endtask

  task automatic bus_read(input logic [11:0] a, output logic [31:0] d);
    sel = 1'b1; wr = 1'b0; addr = a;
    #1;
    d = rdata;
    step();
  endtask

  task automatic chk_read(input string tag, input logic [11:0] a, input logic [31:0] exp);
    logic [31:0] d;
    bus_read(a, d);
    check(tag, d, exp);
  endtask

  // Checks the status, current and line of both banks against the model
  task automatic chk_banks(input string tag);
    logic [31:0] e0, e1;
    int c0, c1;
    e0 = m_masked(0); e1 = m_masked(1);
    c0 = m_cur(0);    c1 = m_cur(1);
    #1;
    check({tag, " irq line R5"}, {31'b0, irq_o}, {31'b0, e0 != 0});
    check({tag, " fiq line R8"}, {31'b0, fiq_o}, {31'b0, e1 != 0});
    chk_read({tag, " irq status R5"}, 12'h000, e0);
    chk_read({tag, " irq current R6"}, 12'h020, c0);
    chk_read({tag, " fiq status R8"}, 12'h100, e1);
    chk_read({tag, " fiq current R6"}, 12'h120, c1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] lfsr, d;
    for (int n = 0; n < 32; n++) m_prio[n] = '0;
    m_en[0] = '0; m_en[1] = '0;
    m_thr[0] = 4'hF; m_thr[1] = 4'hF;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state
    #1;
    check("R1 irq line", {31'b0, irq_o}, 32'h0);
    check("R1 fiq line", {31'b0, fiq_o}, 32'h0);
    chk_read("R1 irq enable", 12'h008, 32'h0);
    chk_read("R1 fiq enable", 12'h108, 32'h0);
    chk_read("R1 polarity", 12'h200, 32'hFFFF_FFFF);
    chk_read("R1 capture", 12'h204, 32'h0);
    chk_read("R1 irq threshold", 12'h02C, 32'hF);
    chk_read("R1 fiq threshold", 12'h12C, 32'hF);
    for (int n = 0; n < 32; n++) chk_read("R1 priority", 12'h300 + 12'(4*n), 32'h0);

    // R2: set/clear enable one bit at a time, fast bank untouched (R8)
    for (int i = 0; i < 32; i++) begin
      bus_write(12'h008, 32'h1 << i);
      chk_read("R2 enable set", 12'h008, m_en[0]);
    end
    bus_write(12'h00C, 32'h5555_5555);
    chk_read("R2 enable clear", 12'h008, 32'hAAAA_AAAA);
    chk_read("R8 fiq enable untouched", 12'h108, 32'h0);
    bus_write(12'h00C, 32'hFFFF_FFFF);
    chk_read("R2 enable all clear", 12'h008, 32'h0);

    // R3: polarity sweep on raw status
    for (int p = 0; p < 3; p++) begin
      bus_write(12'h200, (p == 0) ? 32'hFFFF_FFFF : (p == 1) ? 32'h0 : 32'hFFFF_0000);
      for (int s = 0; s < 4; s++) begin
        src = (s == 0) ? 32'h0 : (s == 1) ? 32'hFFFF_FFFF : (s == 2) ? 32'hA5A5_A5A5 : 32'h1234_5678;
        chk_read("R3 raw status", 12'h004, m_pend());
        chk_read("R3 raw status fiq page", 12'h104, m_pend());
      end
    end
    src = '0;
    bus_write(12'h200, 32'hFFFF_FFFF);

    // R9: priority storage, only 4 bits kept
    bus_write(12'h300, 32'hFFFF_FFF7);
    chk_read("R9 priority width", 12'h300, 32'h7);
    for (int n = 0; n < 32; n++) bus_write(12'h300 + 12'(4*n), 32'((n*5 + 3) % 16));
    for (int n = 0; n < 32; n++) chk_read("R9 priority readback", 12'h300 + 12'(4*n), 32'((n*5 + 3) % 16));

    // R5/R6/R8: threshold sweep with pseudo-random sources
    bus_write(12'h008, 32'hFFFF_FFFF);
    bus_write(12'h108, 32'h0F0F_0F0F);
    chk_read("R8 irq enable", 12'h008, 32'hFFFF_FFFF);
    chk_read("R8 fiq enable", 12'h108, 32'h0F0F_0F0F);
    lfsr = 32'hACE1_2468;
    for (int t = 0; t < 16; t++) begin
      bus_write(12'h02C, 32'(t));
      bus_write(12'h12C, 32'(15 - t));
      for (int k = 0; k < 6; k++) begin
        lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
        src = (k == 0) ? 32'h0 : (k == 1) ? 32'h0001_0001 : (lfsr & {lfsr[15:0], lfsr[31:16]});
        chk_banks("sweep");
      end
    end
    chk_read("R8 irq threshold", 12'h02C, 32'hF);
    chk_read("R8 fiq threshold", 12'h12C, 32'h0);
    bus_write(12'h12C, 32'hF);
    src = '0;

    // R4: capture versus level
    bus_write(12'h204, 32'h0000_0F00);
    src = 32'h0000_0608;
    step();
    src = 32'h0;
    chk_read("R4 captured bits held", 12'h004, 32'h0000_0600);
    chk_read("R4 level bit gone", 12'h004, m_pend());
    chk_banks("R4 capture");

    // R7: acknowledge clears only the current source, per bank
    chk_read("R6 current before ack", 12'h020, 32'd9);
    chk_read("R7 ack data", 12'h028, 32'h0);
    chk_read("R7 only current cleared", 12'h004, 32'h0000_0400);
    chk_read("R7 fiq current", 12'h120, 32'd10);
    chk_read("R7 fiq ack data", 12'h128, 32'h0);
    chk_read("R7 fiq ack clears", 12'h004, 32'h0);
    #1;
    check("R7 irq line after acks", {31'b0, irq_o}, 32'h0);
    chk_read("R7 ack when idle", 12'h028, 32'h0);
    chk_read("R7 idle ack no change", 12'h004, 32'h0);

    // R7: a source still active latches again after acknowledge
    src = 32'h0000_0800;
    step();
    chk_read("R7 ack of active source", 12'h028, 32'h0);
    src = 32'h0;
    chk_read("R7 relatched", 12'h004, 32'h0000_0800);
    chk_banks("R7 relatch");

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule